// File: doc/BRIEF.md
# Multi-Domain Time-of-Day Counter

This block keeps wall-clock time for precision timing work. Each of several independent time domains holds a 48-bit seconds count, a 30-bit nanoseconds count that wraps at one billion, and a 59-bit fractional nanosecond accumulator. On every core clock, every enabled domain adds a programmable 64-bit fixed-point increment. Because the increment has fractional bits, a core clock whose period is not a whole number of nanoseconds still yields exact long-term time.

Software reaches the block through a simple write port. The port loads per-domain increment words, the seconds and nanoseconds staging registers, a domain configuration word and a command word. A new increment sits in a shadow register until the domain's update-disable bit is released, so the rate never changes in the middle of a two-word write. The time itself is never written directly. A command selects one domain and one action: load the staged time, save the current time into capture outputs, or shift the time by a signed nanosecond amount. Each command runs exactly once, on the clock after it is written, and the command slot then falls back to idle. The live time of every domain is also driven out in parallel.

Top module: `tod_clock`

## Requirements
- R1: After reset every domain reads zero time, the capture outputs read zero, all domains are disabled, and every domain's active increment equals the parameter NOMINAL_INC (default 0x1FF0000000000000, 3.9921875 ns).
- R2: The increment is a 64-bit unsigned value in units of 2^-59 ns. For domain d its low word is written at address 2*d and its high word at address 2*d+1. Each enabled domain adds it on every clock, and the fractional part carries into the nanosecond count.
- R3: When the nanosecond count reaches 1,000,000,000 it drops by that amount and the 48-bit seconds count rises by one, including a carry out of the low 32 bits of seconds.
- R4: The configuration word at address 12 holds the enable bits in [3:0] and the update-disable bits in [7:4]. A written increment becomes active only on the clock after the domain's update-disable bit goes from 1 to 0. Until then the domain keeps its previous rate.
- R5: A domain whose enable bit is 0 holds its time unchanged across clocks.
- R6: The staged seconds high part (16 bits) is at address 8, the seconds low word at address 9 and the nanoseconds word at address 10. The command word at address 11 has the action in [1:0] and the domain in [3:2]. A LOAD (action 1) takes effect on the clock after the command write. It sets the domain to the staged time, clears its fraction and replaces that clock's increment. It applies even to a disabled domain.
- R7: A SAVE (action 2) copies the selected domain's time, as it stood just before the executing clock, to the capture outputs. The capture outputs do not change at any other time.
- R8: A DELTA (action 3) adds the nanoseconds word, read as a signed 32-bit number of magnitude under half a second, to the selected domain in the same clock as that clock's increment. A result below zero borrows a second; a result at or above one billion carries a second.
- R9: IDLE is action 0. A command runs on one clock only. A command write that arrives while the previous command is still pending (back-to-back writes) is ignored. The command after that is accepted again.
- R10: A command naming a domain number at or above the domain count changes no domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 32 | Register write data |
| cap_sec_hi_o | output | 16 | Captured seconds, high part |
| cap_sec_lo_o | output | 32 | Captured seconds, low word |
| cap_ns_o | output | 30 | Captured nanoseconds |
| live_sec_o | output | NUM_DOM*48 | Live seconds of every domain, domain d at bits d*48 upward |
| live_ns_o | output | NUM_DOM*30 | Live nanoseconds of every domain, domain d at bits d*30 upward |

## Verification
The per-clock increment and a DELTA command land on the same clock edge. The nanosecond result therefore holds both the step and the signed offset, and only then is it normalised. The bench loads a domain running at exactly 4 ns per clock and samples its live time at the moment the DELTA command is written. It then checks the next clock for that sample plus 4 plus the offset. A negative offset is used to force a borrow from seconds, and a positive one to force a carry. A second overlap is two back-to-back command writes: the first runs on the very edge where the second arrives, and the bench judges that edge from the live time of both named domains.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SAVE  = 2'd2,
        ACT_DELTA = 2'd3
    } tod_act_e;

    localparam int ADDR_W     = 4;
    localparam int WORD_W     = 32;
    localparam int SEC_HI_W   = 16;
    localparam int SEC_W      = SEC_HI_W + WORD_W;
    localparam int NS_W       = 30;
    localparam int NS_PER_SEC = 1_000_000_000;
    localparam int DIS_LSB    = 4;
    localparam int MAX_DOM    = 4;

    localparam logic [ADDR_W-1:0] A_SEC_HI = 4'd8;
    localparam logic [ADDR_W-1:0] A_SEC_LO = 4'd9;
    localparam logic [ADDR_W-1:0] A_NSEC   = 4'd10;
    localparam logic [ADDR_W-1:0] A_CMD    = 4'd11;
    localparam logic [ADDR_W-1:0] A_DOMCFG = 4'd12;

endpackage

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int          NUM_DOM     = 3,
    parameter int          INC_W       = 64,
    parameter logic [63:0] NOMINAL_INC = 64'h1FF0_0000_0000_0000
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [WORD_W-1:0]               wr_data_i,
    output logic [NUM_DOM-1:0][INC_W-1:0]   shd_inc_o,
    output logic [NUM_DOM-1:0]              ena_o,
    output logic [NUM_DOM-1:0]              upd_dis_o,
    output logic [SEC_W-1:0]                ld_sec_o,
    output logic [NS_W-1:0]                 ld_ns_o,
    output logic signed [WORD_W-1:0]        delta_ns_o,
    output logic [NUM_DOM-1:0]              load_o,
    output logic [NUM_DOM-1:0]              delta_o,
    output logic                            save_o,
    output logic [1:0]                      dom_o
);

    localparam int HALF_W = INC_W / 2;

    typedef struct packed {
        logic [NUM_DOM-1:0][INC_W-1:0] inc;
        logic [NUM_DOM-1:0]            ena;
        logic [NUM_DOM-1:0]            dis;
        logic [SEC_HI_W-1:0]           sec_hi;
        logic [WORD_W-1:0]             sec_lo;
        logic [WORD_W-1:0]             nsec;
        tod_act_e                      act;
        logic [1:0]                    dom;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  dom_ok;

    always_comb begin
        regs_d     = regs_q;
        regs_d.act = ACT_IDLE;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (wr_en_i && wr_addr_i == ADDR_W'(2 * d))
                regs_d.inc[d][HALF_W-1:0] = wr_data_i[HALF_W-1:0];
            if (wr_en_i && wr_addr_i == ADDR_W'(2 * d + 1))
                regs_d.inc[d][INC_W-1:HALF_W] = wr_data_i[HALF_W-1:0];
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                A_SEC_HI: regs_d.sec_hi = wr_data_i[SEC_HI_W-1:0];
                A_SEC_LO: regs_d.sec_lo = wr_data_i;
                A_NSEC:   regs_d.nsec   = wr_data_i;
                A_DOMCFG: begin
                    regs_d.ena = wr_data_i[NUM_DOM-1:0];
                    regs_d.dis = wr_data_i[DIS_LSB +: NUM_DOM];
                end
                A_CMD: begin
                    // a command is taken only when the slot is idle
                    if (regs_q.act == ACT_IDLE) begin
                        regs_d.act = tod_act_e'(wr_data_i[1:0]);
                        regs_d.dom = wr_data_i[3:2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q     <= '0;
            regs_q.act <= ACT_IDLE;
            for (int d = 0; d < NUM_DOM; d++) regs_q.inc[d] <= NOMINAL_INC;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dom_ok     = {1'b0, regs_q.dom} < 3'(NUM_DOM);
    assign shd_inc_o  = regs_q.inc;
    assign ena_o      = regs_q.ena;
    assign upd_dis_o  = regs_q.dis;
    assign ld_sec_o   = {regs_q.sec_hi, regs_q.sec_lo};
    assign ld_ns_o    = regs_q.nsec[NS_W-1:0];
    assign delta_ns_o = $signed(regs_q.nsec);
    assign save_o     = (regs_q.act == ACT_SAVE) && dom_ok;
    assign dom_o      = regs_q.dom;

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_sel
        assign load_o[g]  = (regs_q.act == ACT_LOAD)  && (regs_q.dom == 2'(g));
        assign delta_o[g] = (regs_q.act == ACT_DELTA) && (regs_q.dom == 2'(g));
    end

    // R9: a pending command lasts one clock; a write landing on it is dropped
    p_one_shot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.act != ACT_IDLE) |=> (regs_q.act == ACT_IDLE));

    // R10: an out-of-range domain never reaches any domain strobe
    p_no_strobe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dom_ok |-> (load_o == '0 && delta_o == '0 && !save_o));

endmodule

// File: rtl/tod_domain.sv
module tod_domain
    import tod_pkg::*;
#(
    parameter int          INC_W       = 64,
    parameter int          FRAC_W      = 59,
    parameter logic [63:0] NOMINAL_INC = 64'h1FF0_0000_0000_0000
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     ena_i,
    input  logic                     upd_dis_i,
    input  logic [INC_W-1:0]         shd_inc_i,
    input  logic                     load_i,
    input  logic [SEC_W-1:0]         ld_sec_i,
    input  logic [NS_W-1:0]          ld_ns_i,
    input  logic                     delta_i,
    input  logic signed [WORD_W-1:0] delta_ns_i,
    output logic [SEC_W-1:0]         sec_o,
    output logic [NS_W-1:0]          ns_o
);

    localparam int INT_W  = INC_W - FRAC_W;
    localparam int STEP_W = INT_W + 1;
    localparam int SUM_W  = WORD_W + 2;
    localparam logic signed [SUM_W-1:0] NS_S = SUM_W'(NS_PER_SEC);

    typedef struct packed {
        logic [SEC_W-1:0]  sec;
        logic [NS_W-1:0]   ns;
        logic [FRAC_W-1:0] frac;
        logic [INC_W-1:0]  inc;
        logic              dis;
    } dom_t;

    dom_t                     st_d, st_q;
    logic [FRAC_W:0]          frac_sum;
    logic [STEP_W-1:0]        step;
    logic signed [SUM_W-1:0]  dlt;
    logic signed [SUM_W-1:0]  ns_sum;

    always_comb begin
        st_d     = st_q;
        st_d.dis = upd_dis_i;
        // the shadow increment is adopted when the update gate reopens
        if (st_q.dis && !upd_dis_i) st_d.inc = shd_inc_i;

        frac_sum = {1'b0, st_q.frac} + {1'b0, st_q.inc[FRAC_W-1:0]};
        step     = '0;
        if (ena_i) begin
            step      = {1'b0, st_q.inc[INC_W-1:FRAC_W]} + STEP_W'(frac_sum[FRAC_W]);
            st_d.frac = frac_sum[FRAC_W-1:0];
        end

        dlt    = delta_i ? {{(SUM_W-WORD_W){delta_ns_i[WORD_W-1]}}, delta_ns_i} : '0;
        ns_sum = $signed({{(SUM_W-NS_W){1'b0}}, st_q.ns})
               + $signed({{(SUM_W-STEP_W){1'b0}}, step}) + dlt;

        if (ns_sum < 0) begin
            st_d.ns  = NS_W'(ns_sum + NS_S);
            st_d.sec = st_q.sec - SEC_W'(1);
        end else if (ns_sum >= NS_S) begin
            st_d.ns  = NS_W'(ns_sum - NS_S);
            st_d.sec = st_q.sec + SEC_W'(1);
        end else begin
            st_d.ns  = NS_W'(ns_sum);
        end

        if (load_i) begin
            st_d.sec  = ld_sec_i;
            st_d.ns   = ld_ns_i;
            st_d.frac = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q     <= '0;
            st_q.inc <= NOMINAL_INC;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_o = st_q.sec;
    assign ns_o  = st_q.ns;

    // R3: counting alone keeps nanoseconds below one second
    p_ns_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !delta_i && st_q.ns < NS_W'(NS_PER_SEC)) |=> (st_q.ns < NS_W'(NS_PER_SEC)));

    // R4: the active rate moves only on a released update gate
    p_inc_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(st_q.dis && !upd_dis_i) |=> $stable(st_q.inc));

    // R5: a disabled domain without commands holds its time
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ena_i && !load_i && !delta_i) |=> ($stable(st_q.sec) && $stable(st_q.ns)));

    // R6: a load places the staged time on the next clock
    p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (st_q.sec == $past(ld_sec_i) && st_q.ns == $past(ld_ns_i) && st_q.frac == '0));

endmodule

// File: rtl/tod_capture.sv
module tod_capture
    import tod_pkg::*;
#(
    parameter int NUM_DOM = 3
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       save_i,
    input  logic [1:0]                 dom_i,
    input  logic [NUM_DOM*SEC_W-1:0]   live_sec_i,
    input  logic [NUM_DOM*NS_W-1:0]    live_ns_i,
    output logic [SEC_W-1:0]           cap_sec_o,
    output logic [NS_W-1:0]            cap_ns_o
);

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (save_i) begin
            for (int d = 0; d < NUM_DOM; d++) begin
                if (dom_i == 2'(d)) begin
                    cap_d.sec = live_sec_i[d*SEC_W +: SEC_W];
                    cap_d.ns  = live_ns_i[d*NS_W +: NS_W];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cap_q <= '0;
        else         cap_q <= cap_d;
    end

    assign cap_sec_o = cap_q.sec;
    assign cap_ns_o  = cap_q.ns;

    // R7: capture outputs move only on a save
    p_cap_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !save_i |=> ($stable(cap_q.sec) && $stable(cap_q.ns)));

endmodule

// File: rtl/tod_clock.sv
module tod_clock
    import tod_pkg::*;
#(
    parameter int          NUM_DOM     = 3,
    parameter int          INC_W       = 64,
    parameter int          FRAC_W      = 59,
    parameter logic [63:0] NOMINAL_INC = 64'h1FF0_0000_0000_0000
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       wr_en_i,
    input  logic [3:0]                 wr_addr_i,
    input  logic [31:0]                wr_data_i,
    output logic [15:0]                cap_sec_hi_o,
    output logic [31:0]                cap_sec_lo_o,
    output logic [29:0]                cap_ns_o,
    output logic [NUM_DOM*48-1:0]      live_sec_o,
    output logic [NUM_DOM*30-1:0]      live_ns_o
);

    logic [NUM_DOM-1:0][INC_W-1:0] shd_inc;
    logic [NUM_DOM-1:0]            ena, upd_dis, load, delta;
    logic [SEC_W-1:0]              ld_sec, cap_sec;
    logic [NS_W-1:0]               ld_ns;
    logic signed [WORD_W-1:0]      delta_ns;
    logic                          save;
    logic [1:0]                    dom;

    initial begin
        if (NUM_DOM < 1 || NUM_DOM > MAX_DOM) $error("NUM_DOM out of range");
    end

    tod_regs #(
        .NUM_DOM     (NUM_DOM),
        .INC_W       (INC_W),
        .NOMINAL_INC (NOMINAL_INC)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .shd_inc_o  (shd_inc),
        .ena_o      (ena),
        .upd_dis_o  (upd_dis),
        .ld_sec_o   (ld_sec),
        .ld_ns_o    (ld_ns),
        .delta_ns_o (delta_ns),
        .load_o     (load),
        .delta_o    (delta),
        .save_o     (save),
        .dom_o      (dom)
    );

    for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
        tod_domain #(
            .INC_W       (INC_W),
            .FRAC_W      (FRAC_W),
            .NOMINAL_INC (NOMINAL_INC)
        ) u_dom (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ena_i      (ena[g]),
            .upd_dis_i  (upd_dis[g]),
            .shd_inc_i  (shd_inc[g]),
            .load_i     (load[g]),
            .ld_sec_i   (ld_sec),
            .ld_ns_i    (ld_ns),
            .delta_i    (delta[g]),
            .delta_ns_i (delta_ns),
            .sec_o      (live_sec_o[g*SEC_W +: SEC_W]),
            .ns_o       (live_ns_o[g*NS_W +: NS_W])
        );
    end

    tod_capture #(
        .NUM_DOM (NUM_DOM)
    ) u_cap (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .save_i     (save),
        .dom_i      (dom),
        .live_sec_i (live_sec_o),
        .live_ns_i  (live_ns_o),
        .cap_sec_o  (cap_sec),
        .cap_ns_o   (cap_ns_o)
    );

    assign cap_sec_hi_o = cap_sec[SEC_W-1:WORD_W];
    assign cap_sec_lo_o = cap_sec[WORD_W-1:0];

endmodule

// File: tb/sim_tod_clock.sv
`timescale 1ns/1ps
module sim_tod_clock;

    localparam int ND = 3;
    localparam logic [63:0] INC4 = 64'h2000_0000_0000_0000;
    localparam logic [63:0] INC8 = 64'h4000_0000_0000_0000;

    typedef struct packed {
        logic [1:0]  dom;
        logic [63:0] inc;
        logic [47:0] sec;
        logic [29:0] ns;
        logic [15:0] cyc;
    } vec_t;

    // stimulus vectors; expected time is computed by exp_time below
    localparam vec_t VEC [6] = '{
        '{2'd0, INC4,                  48'd5,            30'd100,         16'd10},
        '{2'd0, INC4,                  48'd5,            30'd999_999_990, 16'd3},
        '{2'd1, 64'h1FF0000000000000,  48'h0000_1234_5678, 30'd0,         16'd128},
        '{2'd2, 64'h0CC6666666666666,  48'h0001_FFFF_FFFF, 30'd999_999_000, 16'd640},
        '{2'd2, 64'h0CC6666666666666,  48'd0,            30'd0,           16'd10},
        '{2'd1, 64'h0000000000000001,  48'd0,            30'd7,           16'd50}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [15:0]       cap_sec_hi;
    logic [31:0]       cap_sec_lo;
    logic [29:0]       cap_ns;
    logic [ND*48-1:0]  live_sec;
    logic [ND*30-1:0]  live_ns;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tod_clock u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .cap_sec_hi_o (cap_sec_hi),
        .cap_sec_lo_o (cap_sec_lo),
        .cap_ns_o     (cap_ns),
        .live_sec_o   (live_sec),
        .live_ns_o    (live_ns)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [47:0] sec_of(input int d);
        return live_sec[d*48 +: 48];
    endfunction

    function automatic logic [29:0] ns_of(input int d);
        return live_ns[d*30 +: 30];
    endfunction

    function automatic logic [31:0] cmd(input int act, input int d);
        return 32'((d << 2) | act);
    endfunction

    // time after cyc increments from a loaded value with zero fraction
    task automatic exp_time(input logic [63:0] inc, input logic [47:0] s, input logic [29:0] n,
                            input int cyc, output logic [47:0] es, output logic [29:0] en);
        logic [127:0] tot, nst;
        tot = (128'(n) << 59) + 128'(cyc) * 128'(inc);
        nst = tot >> 59;
        es  = s + 48'(nst / 128'(1_000_000_000));
        en  = 30'(nst % 128'(1_000_000_000));
    endtask

    task automatic norm_add(input logic [47:0] s, input logic [29:0] n, input longint add,
                            output logic [47:0] es, output logic [29:0] en);
        longint t;
        t  = longint'(n) + add;
        es = s;
        if (t < 0) begin t += 1_000_000_000; es = s - 48'd1; end
        else if (t >= 1_000_000_000) begin t -= 1_000_000_000; es = s + 48'd1; end
        en = 30'(t);
    endtask

    task automatic stage(input logic [47:0] s, input logic [29:0] n);
        wr(4'd8, {16'd0, s[47:32]});
        wr(4'd9, s[31:0]);
        wr(4'd10, {2'b00, n});
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        logic [47:0] es, ls, hs;
        logic [29:0] en, ln, hn;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int d = 0; d < ND; d++) begin
            chk("R1 live sec", 64'(sec_of(d)), 64'd0);
            chk("R1 live ns", 64'(ns_of(d)), 64'd0);
        end
        chk("R1 cap", {cap_sec_hi, cap_sec_lo}, 64'd0);
        chk("R1 cap ns", 64'(cap_ns), 64'd0);
        repeat (5) @(negedge clk);
        chk("R1 disabled after reset", 64'(ns_of(0)), 64'd0);

        // R1: nominal increment without any increment write
        wr(4'd12, 32'h2);
        stage(48'd0, 30'd0);
        wr(4'd11, cmd(1, 1));
        @(negedge clk);
        repeat (128) @(negedge clk);
        chk("R1 nominal rate", 64'(ns_of(1)), 64'd511);

        // R2 R3 R6 R7: vector table
        for (int i = 0; i < 6; i++) begin
            wr(4'(2 * VEC[i].dom), VEC[i].inc[31:0]);
            wr(4'(2 * VEC[i].dom + 1), VEC[i].inc[63:32]);
            wr(4'd12, 32'h7 | (32'h10 << VEC[i].dom));
            wr(4'd12, 32'h7);
            stage(VEC[i].sec, VEC[i].ns);
            wr(4'd11, cmd(1, int'(VEC[i].dom)));
            @(negedge clk);
            chk("R6 load value", {16'd0, sec_of(int'(VEC[i].dom))}, {16'd0, VEC[i].sec});
            repeat (int'(VEC[i].cyc)) @(negedge clk);
            exp_time(VEC[i].inc, VEC[i].sec, VEC[i].ns, int'(VEC[i].cyc), es, en);
            chk("R2 R3 live ns", 64'(ns_of(int'(VEC[i].dom))), 64'(en));
            chk("R3 live sec", 64'(sec_of(int'(VEC[i].dom))), 64'(es));
            wr(4'd11, cmd(2, int'(VEC[i].dom)));
            ls = sec_of(int'(VEC[i].dom));
            ln = ns_of(int'(VEC[i].dom));
            @(negedge clk);
            chk("R7 save ns", 64'(cap_ns), 64'(ln));
            chk("R7 save sec", {cap_sec_hi, cap_sec_lo}, 64'(ls));
            repeat (3) @(negedge clk);
            chk("R7 capture held", 64'(cap_ns), 64'(ln));
        end

        // R8: delta with borrow, dom0 at 4 ns per clock
        stage(48'd10, 30'd100);
        wr(4'd11, cmd(1, 0));
        @(negedge clk);
        wr(4'd10, 32'hFFFF_FF38);   // -200
        wr(4'd11, cmd(3, 0));
        ls = sec_of(0); ln = ns_of(0);
        @(negedge clk);
        norm_add(ls, ln, 4 - 200, es, en);
        chk("R8 delta borrow ns", 64'(ns_of(0)), 64'(en));
        chk("R8 delta borrow sec", 64'(sec_of(0)), 64'(es));

        // R8: delta with carry
        stage(48'd20, 30'd999_999_000);
        wr(4'd11, cmd(1, 0));
        @(negedge clk);
        wr(4'd10, 32'd5000);
        wr(4'd11, cmd(3, 0));
        ls = sec_of(0); ln = ns_of(0);
        @(negedge clk);
        norm_add(ls, ln, 4 + 5000, es, en);
        chk("R8 delta carry ns", 64'(ns_of(0)), 64'(en));
        chk("R8 delta carry sec", 64'(sec_of(0)), 64'(es));

        // R4: shadow increment not active until the gate is released
        wr(4'd0, INC8[31:0]);
        wr(4'd1, INC8[63:32]);
        stage(48'd0, 30'd0);
        wr(4'd11, cmd(1, 0));
        @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R4 old rate kept", 64'(ns_of(0)), 64'd40);
        wr(4'd12, 32'h17);
        wr(4'd12, 32'h07);
        stage(48'd0, 30'd0);
        wr(4'd11, cmd(1, 0));
        @(negedge clk);
        repeat (10) @(negedge clk);
        chk("R4 new rate", 64'(ns_of(0)), 64'd80);

        // R5: disabled domain holds
        wr(4'd12, 32'h6);
        hs = sec_of(0); hn = ns_of(0);
        repeat (20) @(negedge clk);
        chk("R5 hold ns", 64'(ns_of(0)), 64'(hn));
        chk("R5 hold sec", 64'(sec_of(0)), 64'(hs));

        // R9: back-to-back commands, second one dropped
        stage(48'd77, 30'd777);
        wr(4'd11, cmd(1, 2));
        wr(4'd11, cmd(1, 0));
        chk("R9 first command ran", 64'(ns_of(2)), 64'd777);
        repeat (3) @(negedge clk);
        chk("R9 second command ignored", 64'(ns_of(0)), 64'(hn));
        // R9: slot back to idle; R6 load applies to a disabled domain
        wr(4'd11, cmd(1, 0));
        @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R9 R6 later command accepted", 64'(ns_of(0)), 64'd777);
        chk("R6 disabled load sec", 64'(sec_of(0)), 64'd77);

        // R10: domain number 3 changes nothing
        stage(48'd1, 30'd1);
        wr(4'd11, cmd(1, 3));
        repeat (3) @(negedge clk);
        chk("R10 out of range domain", 64'(ns_of(0)), 64'd777);
        chk("R10 out of range sec", 64'(sec_of(0)), 64'd77);

        summary();
        $finish;
    end

endmodule